// File: doc/BRIEF.md
# Asymmetric Serial Clock Phase Generator

This block generates the serial clock for a two-wire bus master from a fast source clock. The high and low halves of each clock period have their own cycle counts, so the duty cycle can be set to roughly 40 % high and 60 % low. A separate count sets how long the clock stays high after a START condition before the first low phase.

The configuration arrives as two packed 32-bit divider words and one START-hold word. Each 32-bit phase count is split into two 16-bit halves, one half in each divider word. Software normally derives the counts as follows. The prescale is the source frequency divided by four times the bus frequency, minus one. The high count is four fifths of the prescale and the low count is six fifths of it. The hold count is the hold time multiplied by the source frequency.

With a 26 MHz source, 400 kHz operation gives high 12, low 18 and hold 15. 100 kHz operation gives high 51, low 76 and hold 104. The byte engine that follows this block uses three one-cycle pulses: one at the end of the START hold, one when the clock rises and one when it falls. A single enable input starts and stops the generator.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, and from reset, `scl` is 1 and none of `hold_done`, `rise` or `fall` pulses.
- R2: The high count is `{div_word1[31:16], div_word0[31:16]}` and the low count is `{div_word1[15:0], div_word0[15:0]}`.
- R3: If `enable` is first sampled high at clock edge E, `scl` stays 1 until edge E+H, where H is the START-hold count. At edge E+H, `scl` goes to 0 and `hold_done` pulses for one cycle.
- R4: Each low phase lasts L cycles, where L is the low count. It ends with `scl` going to 1 and a one-cycle `rise` pulse.
- R5: Each high phase after the first low phase lasts the high count in cycles. It ends with `scl` going to 0 and a one-cycle `fall` pulse.
- R6: A high, low or hold count of zero acts as a count of one.
- R7: When `enable` is sampled low in any phase, `scl` is 1 after that edge and no pulse is produced. The next enable starts again with a full START hold.
- R8: Divider and hold inputs are captured at the edge where `enable` is first sampled high. Changes to them while enabled have no effect until the next enable.
- R9: At most one of `hold_done`, `rise` and `fall` is high in any cycle, and `scl` only falls together with `hold_done` or `fall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low returns it to idle |
| div_word0 | input | 32 | Low 16-bit halves: high count in [31:16], low count in [15:0] |
| div_word1 | input | 32 | Upper 16-bit halves: high count in [31:16], low count in [15:0] |
| hold_cnt | input | 32 | START hold length in source cycles |
| scl | output | 1 | Serial clock level |
| hold_done | output | 1 | One-cycle pulse when the START hold ends |
| rise | output | 1 | One-cycle pulse when the clock goes high |
| fall | output | 1 | One-cycle pulse when a high phase ends |

## Verification
The hardest case to reach from the ports is a phase count that uses the upper 16-bit halves, because it takes more than 65,536 cycles to see. The stimulus runs one full period with both upper halves set to 1 and places the expected edge times 65,537 and 65,538 cycles apart. This makes a swapped or dropped half visible. Two further cases check the capture of configuration and the restart after a disable. In the first, the inputs are changed in the middle of a run. In the second, enable is dropped in the middle of a low phase and then raised again.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;
  parameter int unsigned HALF_W = 16;
  localparam int unsigned CNT_W = 2 * HALF_W;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  typedef struct packed {
    cnt_t hold;
    cnt_t low;
    cnt_t high;
  } scl_cfg_t;

  // high count: upper halves of both words, word1 holds the upper bits
  function automatic cnt_t high_from_words(input cnt_t w0, input cnt_t w1);
    return {w1[CNT_W-1:HALF_W], w0[CNT_W-1:HALF_W]};
  endfunction

  // low count: lower halves of both words, word1 holds the upper bits
  function automatic cnt_t low_from_words(input cnt_t w0, input cnt_t w1);
    return {w1[HALF_W-1:0], w0[HALF_W-1:0]};
  endfunction

  // a zero count would stall the timer; treat it as one cycle
  function automatic cnt_t at_least_one(input cnt_t c);
    return (c == '0) ? cnt_t'(1) : c;
  endfunction
endpackage

// File: rtl/scl_cfg_capture.sv
module scl_cfg_capture
  import scl_tim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  cnt_t     div_word0,
  input  cnt_t     div_word1,
  input  cnt_t     hold_cnt,
  output scl_cfg_t cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{hold: cnt_t'(1), low: cnt_t'(1), high: cnt_t'(1)};
    end else if (capture) begin
      cfg.hold <= at_least_one(hold_cnt);
      cfg.low  <= at_least_one(low_from_words(div_word0, div_word1));
      cfg.high <= at_least_one(high_from_words(div_word0, div_word1));
    end
  end

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cfg));

  assert_no_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hold != '0) && (cfg.low != '0) && (cfg.high != '0));
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_tim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  cnt_t target,
  output logic expired
);
  cnt_t cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= cnt_t'(1);
    else if (restart) cnt <= cnt_t'(1);
    else              cnt <= cnt + cnt_t'(1);
  end

  assign expired = (cnt >= target);

  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= target);
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_tim_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   expired,
  output phase_e phase,
  output logic   restart,
  output logic   capture,
  output logic   scl,
  output logic   hold_done,
  output logic   rise,
  output logic   fall
);
  assign capture = (phase == PH_IDLE) && enable;
  assign restart = (phase == PH_IDLE) || expired || !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      scl       <= 1'b1;
      hold_done <= 1'b0;
      rise      <= 1'b0;
      fall      <= 1'b0;
    end else begin
      hold_done <= 1'b0;
      rise      <= 1'b0;
      fall      <= 1'b0;
      if (!enable) begin
        phase <= PH_IDLE;
        scl   <= 1'b1;
      end else begin
        unique case (phase)
          PH_IDLE: phase <= PH_HOLD;
          PH_HOLD: if (expired) begin
            phase     <= PH_LOW;
            scl       <= 1'b0;
            hold_done <= 1'b1;
          end
          PH_LOW: if (expired) begin
            phase <= PH_HIGH;
            scl   <= 1'b1;
            rise  <= 1'b1;
          end
          PH_HIGH: if (expired) begin
            phase <= PH_LOW;
            scl   <= 1'b0;
            fall  <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assert_hold_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |-> ($past(scl) && !scl));

  assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (!$past(scl) && scl));

  assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> ($past(scl) && !scl));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] div_word0,
  input  logic [CNT_W-1:0] div_word1,
  input  logic [CNT_W-1:0] hold_cnt,
  output logic             scl,
  output logic             hold_done,
  output logic             rise,
  output logic             fall
);
  scl_cfg_t cfg;
  phase_e   phase;
  logic     restart;
  logic     capture;
  logic     expired;
  cnt_t     target;

  scl_cfg_capture u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .div_word0 (div_word0),
    .div_word1 (div_word1),
    .hold_cnt  (hold_cnt),
    .cfg       (cfg)
  );

  always_comb begin
    unique case (phase)
      PH_LOW:  target = cfg.low;
      PH_HIGH: target = cfg.high;
      default: target = cfg.hold;
    endcase
  end

  scl_phase_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .target  (target),
    .expired (expired)
  );

  scl_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .expired   (expired),
    .phase     (phase),
    .restart   (restart),
    .capture   (capture),
    .scl       (scl),
    .hold_done (hold_done),
    .rise      (rise),
    .fall      (fall)
  );

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl && !hold_done && !rise && !fall));

  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hold_done, rise, fall}));

  assert_fall_has_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> (hold_done || fall));

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !enable) |=> (phase == PH_IDLE));
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] div_word0 = '0;
  logic [31:0] div_word1 = '0;
  logic [31:0] hold_cnt = '0;
  logic        scl, hold_done, rise, fall;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .div_word0(div_word0), .div_word1(div_word1), .hold_cnt(hold_cnt),
    .scl(scl), .hold_done(hold_done), .rise(rise), .fall(fall)
  );

  always #5 clk = ~clk;

  typedef struct { int kind; int edge_no; } ev_t;   // kind 0 hold, 1 rise, 2 fall
  ev_t   q[$];
  int    edges = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  always @(posedge clk) edges++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, cur_tag, what, act, exp);
    end
  endtask

  function automatic string kind_req(input int k);
    return (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
  endfunction

  task automatic take_pulse(input int k);
    ev_t e;
    int  want_scl;
    if (q.size() == 0) begin
      chk(1'b0, "R7", $sformatf("unexpected pulse kind %0d at edge %0d", k, edges), k, -1);
      return;
    end
    e = q.pop_front();
    chk(e.kind == k, kind_req(e.kind), "pulse kind", k, e.kind);
    chk(e.edge_no == edges, kind_req(e.kind), "pulse edge", edges, e.edge_no);
    want_scl = (k == 1) ? 1 : 0;
    chk(int'(scl) == want_scl, kind_req(k), "scl level at pulse", int'(scl), want_scl);
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(hold_done) + int'(rise) + int'(fall) > 1)
        chk(1'b0, "R9", "several pulses in one cycle",
            int'(hold_done) + int'(rise) + int'(fall), 1);
      if (hold_done) take_pulse(0);
      if (rise)      take_pulse(1);
      if (fall)      take_pulse(2);
    end
  end

  function automatic int eff(input logic [31:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // one enabled run: expected events are queued, enable is dropped so that
  // it is first sampled low at edge E0+stop
  task automatic run_case(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] hc, input int stop, input bit disturb);
    int hi_c, lo_c, ho_c, e0, t;
    ev_t e;
    hi_c = eff((w1 & 32'hFFFF_0000) + (w0 >> 16));
    lo_c = eff((w1 << 16) + (w0 & 32'h0000_FFFF));
    ho_c = eff(hc);
    @(negedge clk);
    div_word0 = w0; div_word1 = w1; hold_cnt = hc;
    e0 = edges + 1;
    t  = e0 + ho_c;
    if (t < e0 + stop) begin e.kind = 0; e.edge_no = t; q.push_back(e); end
    while (1) begin
      t += lo_c;
      if (t >= e0 + stop) break;
      e.kind = 1; e.edge_no = t; q.push_back(e);
      t += hi_c;
      if (t >= e0 + stop) break;
      e.kind = 2; e.edge_no = t; q.push_back(e);
    end
    enable = 1'b1;
    if (disturb) begin
      repeat (2) @(negedge clk);
      div_word0 = 32'h0001_0001; div_word1 = 32'h0; hold_cnt = 32'd9;  // R8: ignored
    end
    while (edges < e0 + stop - 1) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl == 1'b1, "R7", "scl after disable", int'(scl), 1);
    repeat (3) begin
      @(negedge clk);
      chk(scl == 1'b1, "R1", "scl while idle", int'(scl), 1);
    end
    chk(q.size() == 0, cur_tag, "missing expected pulses", q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl == 1'b1, "R1", "scl in reset", int'(scl), 1);
    chk({hold_done, rise, fall} == 3'b000, "R1", "pulses in reset",
        int'({hold_done, rise, fall}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl == 1'b1, "R1", "scl idle after reset", int'(scl), 1);

    cur_tag = "R3"; run_case({16'd12, 16'd18}, 32'h0, 32'd15, 15 + 3*30 + 5, 1'b0);
    cur_tag = "R4"; run_case({16'd51, 16'd76}, 32'h0, 32'd104, 104 + 2*127 + 3, 1'b0);
    cur_tag = "R6"; run_case(32'h0, 32'h0, 32'h0, 12, 1'b0);
    cur_tag = "R8"; run_case({16'd5, 16'd7}, 32'h0, 32'd3, 3 + 3*12, 1'b1);
    cur_tag = "R7"; run_case({16'd4, 16'd6}, 32'h0, 32'd2, 2 + 3, 1'b0);
    cur_tag = "R7"; run_case({16'd4, 16'd6}, 32'h0, 32'd2, 2 + 2*10 + 1, 1'b0);
    cur_tag = "R5"; run_case({16'd3, 16'd2}, 32'h0, 32'd1, 1 + 4*5, 1'b0);
    cur_tag = "R2"; run_case({16'd1, 16'd2}, {16'd1, 16'd1}, 32'd5,
                             5 + 65538 + 65537 + 2, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (%s): actual=%0d expected=%0d", cur_tag, edges, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule